// File: doc/BRIEF.md
# Burst Memory-to-Memory Word Copier

This block moves a run of 32-bit words from one region of external memory to another without processor help. Software fills in a source pointer, a destination pointer and a word count through a small register port, then sets a start bit. The engine reads the source through an AXI4 read manager and writes the destination through an AXI4 write manager. Word i of the source lands at word i of the destination.

The copy is cut into incrementing bursts. Each burst sends one address followed by several data beats. A burst stops at the configured maximum length, at a 4 KB page edge, or at the end of the run, whichever comes first. Read data passes through one word FIFO to the write side. That FIFO holds exactly one maximum burst. The numbers of read bursts and write bursts in flight are capped by two separate parameters.

A status word reports busy, done and a sticky error flag. Done is raised only after the last write response has come back.

Top module: `burst_copy_engine`

## Requirements
- R1: For every i from 0 to count-1, the word read from source + 4*i is written to destination + 4*i, and the data is unchanged.
- R2: Every burst is incrementing (burst code 1) with 4-byte beats (size code 2), and its address is presented once. Burst addresses follow each other with no gap. AxLEN is the beat count minus 1. The write data carries exactly AxLEN+1 beats per address, with last set on the final beat only. Byte enables are all ones.
- R3: No burst is longer than MAX_BURST beats. Over one copy, the read beats and the write beats each add up to count, so the final burst carries what is left.
- R4: No burst crosses a 4096-byte address boundary.
- R5: Accepted read addresses whose last data beat has not yet arrived never exceed MAX_RD_OUT. Accepted write addresses without a response never exceed MAX_WR_OUT.
- R6: A read burst is requested only when the FIFO has room for its beats plus all beats still owed. Read data is always accepted, and the FIFO never overflows.
- R7: A write address is issued only when the FIFO holds the whole burst. The write data follows its address, and once valid it stays valid until the last beat is accepted.
- R8: Done is set only after every write response of the copy has been received. While the engine is not busy, no address or write-data valid is driven.
- R9: A nonzero read or write response code sets a sticky error flag. The flag stays set through done and is cleared by the next start.
- R10: Starting with a count of zero sets done on the following clock edge and issues no bus transfer.
- R11: Register map (byte offsets on the 4-bit address): 0x0 source pointer, 0x4 destination pointer, 0x8 word count, 0xC control/status. Writing 1 to bit 0 of 0xC while idle starts a copy. Status bits are 0 busy, 1 done, 2 error. Read data appears on the edge after the read strobe. Register writes are ignored while busy. All registers reset to zero.
- R12: An address valid, once raised, stays high with its address and length unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, registered |
| m_araddr | output | 32 | Read burst address |
| m_arlen | output | 8 | Read burst beats minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Final read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_awaddr | output | 32 | Write burst address |
| m_awlen | output | 8 | Write burst beats minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte enables |
| m_wlast | output | 1 | Final write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The assertions assume the memory follows the protocol. It returns read beats only for bursts it has accepted, in order, with last on the final beat. It returns one write response per completed burst. It never sends read data for beats that were not requested. The bench memory model builds its read and write replies from queues of accepted addresses and pops a burst only when its last beat has gone out. It inserts random stalls on every ready and valid, but never answers early or more than once. The stimulus places the source so that bursts meet a 4 KB edge. It also injects one error response to exercise the sticky flag.

// File: rtl/copy_pkg.sv
package copy_pkg;

  typedef enum logic [1:0] {WS_IDLE, WS_ADDR, WS_DATA} wr_state_t;

  // Beats for the next burst: limited by remaining words, the burst cap
  // and the distance to the next 4 KB page edge.
  function automatic logic [31:0] clip_beats(input logic [31:0] addr,
                                             input logic [31:0] left,
                                             input logic [31:0] cap);
    logic [31:0] to_page;
    logic [31:0] n;
    to_page = (32'd4096 - {20'd0, addr[11:0]}) >> 2;
    n = left;
    if (n > cap) n = cap;
    if (n > to_page) n = to_page;
    return n;
  endfunction

endpackage

// File: rtl/copy_fifo.sv
module copy_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      count <= count + (push ? CW'(1) : CW'(0)) - (pop ? CW'(1) : CW'(0));
    end
  end

  assign dout = mem[rp_q];

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)) || pop);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);
endmodule

// File: rtl/copy_rd_ctrl.sv
module copy_rd_ctrl import copy_pkg::*; #(
  parameter int MAX_BURST = 16,
  parameter int MAX_OUT   = 1,
  parameter int DEPTH     = 16,
  parameter int CW        = 5,
  localparam int OW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   base,
  input  logic [31:0]   total,
  input  logic [CW-1:0] fifo_count,
  output logic [31:0]   araddr,
  output logic [7:0]    arlen,
  output logic          arvalid,
  input  logic          arready,
  input  logic          rvalid,
  input  logic          rlast,
  input  logic [1:0]    rresp,
  output logic          push,
  output logic          err
);
  logic [31:0]   addr_q, left_q, plan, free_w, len_w;
  logic [CW-1:0] resv_q;
  logic [OW-1:0] infl_q;
  logic          issue;

  always_comb begin
    plan   = clip_beats(addr_q, left_q, 32'(MAX_BURST));
    free_w = 32'(DEPTH) - 32'(fifo_count) - 32'(resv_q);
    len_w  = (plan > free_w) ? free_w : plan;
    issue  = !arvalid && (left_q != '0) && (infl_q < OW'(MAX_OUT)) && (free_w != '0);
  end

  assign push = rvalid;
  assign err  = rvalid && (rresp != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      left_q  <= '0;
      araddr  <= '0;
      arlen   <= '0;
      arvalid <= 1'b0;
      resv_q  <= '0;
      infl_q  <= '0;
    end else begin
      if (start) begin
        addr_q <= base;
        left_q <= total;
      end else if (issue) begin
        araddr  <= addr_q;
        arlen   <= 8'(len_w - 32'd1);
        arvalid <= 1'b1;
        addr_q  <= addr_q + (len_w << 2);
        left_q  <= left_q - len_w;
      end else if (arvalid && arready) begin
        arvalid <= 1'b0;
      end
      resv_q <= resv_q + (issue ? CW'(len_w) : CW'(0)) - (rvalid ? CW'(1) : CW'(0));
      infl_q <= infl_q + (issue ? OW'(1) : OW'(0)) - ((rvalid && rlast) ? OW'(1) : OW'(0));
    end
  end

  p_ar_hold_r12: assert property (@(posedge clk) disable iff (rst)
    arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));
  p_ar_page_r4: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> ({20'd0, araddr[11:0]} + ((32'(arlen) + 32'd1) << 2)) <= 32'd4096);
  p_ar_cap_r3: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> 32'(arlen) < 32'(MAX_BURST));
  p_space_r6: assert property (@(posedge clk) disable iff (rst)
    32'(fifo_count) + 32'(resv_q) <= 32'(DEPTH));
  p_owed_r6: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> resv_q != '0);
  p_rd_out_r5: assert property (@(posedge clk) disable iff (rst)
    32'(infl_q) <= 32'(MAX_OUT));
endmodule

// File: rtl/copy_wr_ctrl.sv
module copy_wr_ctrl import copy_pkg::*; #(
  parameter int MAX_BURST = 16,
  parameter int MAX_OUT   = 1,
  parameter int CW        = 5,
  localparam int OW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   base,
  input  logic [31:0]   total,
  input  logic [CW-1:0] fifo_count,
  input  logic [31:0]   fifo_dout,
  output logic          pop,
  output logic [31:0]   awaddr,
  output logic [7:0]    awlen,
  output logic          awvalid,
  input  logic          awready,
  output logic [31:0]   wdata,
  output logic          wlast,
  output logic          wvalid,
  input  logic          wready,
  input  logic          bvalid,
  input  logic [1:0]    bresp,
  output logic          err,
  output logic          idle
);
  wr_state_t     st_q;
  logic [31:0]   addr_q, left_q, plan;
  logic [7:0]    beat_q;
  logic [OW-1:0] bpend_q;
  logic          go;

  always_comb begin
    plan = clip_beats(addr_q, left_q, 32'(MAX_BURST));
    go   = (st_q == WS_IDLE) && (left_q != '0) && (bpend_q < OW'(MAX_OUT))
           && (32'(fifo_count) >= plan);
  end

  assign wvalid = (st_q == WS_DATA);
  assign wlast  = wvalid && (beat_q == awlen);
  assign wdata  = fifo_dout;
  assign pop    = wvalid && wready;
  assign err    = bvalid && (bresp != 2'b00);
  assign idle   = (st_q == WS_IDLE) && (left_q == '0) && (bpend_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= WS_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      awaddr  <= '0;
      awlen   <= '0;
      awvalid <= 1'b0;
      beat_q  <= '0;
      bpend_q <= '0;
    end else begin
      if (start) begin
        addr_q <= base;
        left_q <= total;
      end
      case (st_q)
        WS_IDLE: if (go) begin
          awaddr  <= addr_q;
          awlen   <= 8'(plan - 32'd1);
          awvalid <= 1'b1;
          addr_q  <= addr_q + (plan << 2);
          left_q  <= left_q - plan;
          beat_q  <= '0;
          st_q    <= WS_ADDR;
        end
        WS_ADDR: if (awready) begin
          awvalid <= 1'b0;
          st_q    <= WS_DATA;
        end
        default: if (pop) begin
          beat_q <= beat_q + 8'd1;
          if (beat_q == awlen) st_q <= WS_IDLE;
        end
      endcase
      bpend_q <= bpend_q + (go ? OW'(1) : OW'(0)) - (bvalid ? OW'(1) : OW'(0));
    end
  end

  p_aw_hold_r12: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
  p_aw_page_r4: assert property (@(posedge clk) disable iff (rst)
    awvalid |-> ({20'd0, awaddr[11:0]} + ((32'(awlen) + 32'd1) << 2)) <= 32'd4096);
  p_w_hold_r7: assert property (@(posedge clk) disable iff (rst)
    wvalid && !wready |=> wvalid && $stable(wdata));
  p_w_whole_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(awvalid) |-> 32'(fifo_count) >= 32'(awlen) + 32'd1);
  p_wr_out_r5: assert property (@(posedge clk) disable iff (rst)
    32'(bpend_q) <= 32'(MAX_OUT));
endmodule

// File: rtl/burst_copy_engine.sv
module burst_copy_engine #(
  parameter int MAX_BURST  = 16,
  parameter int MAX_RD_OUT = 1,
  parameter int MAX_WR_OUT = 1,
  localparam int DEPTH = MAX_BURST,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic        cfg_re,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [31:0] m_araddr,
  output logic [7:0]  m_arlen,
  output logic [2:0]  m_arsize,
  output logic [1:0]  m_arburst,
  output logic        m_arvalid,
  input  logic        m_arready,
  input  logic [31:0] m_rdata,
  input  logic [1:0]  m_rresp,
  input  logic        m_rlast,
  input  logic        m_rvalid,
  output logic        m_rready,
  output logic [31:0] m_awaddr,
  output logic [7:0]  m_awlen,
  output logic [2:0]  m_awsize,
  output logic [1:0]  m_awburst,
  output logic        m_awvalid,
  input  logic        m_awready,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_wstrb,
  output logic        m_wlast,
  output logic        m_wvalid,
  input  logic        m_wready,
  input  logic [1:0]  m_bresp,
  input  logic        m_bvalid,
  output logic        m_bready
);
  logic [31:0]   src_q, dst_q, cnt_q;
  logic          busy_q, done_q, err_q, start_q;
  logic          push, pop, rd_err, wr_err, wr_idle;
  logic [31:0]   fifo_dout;
  logic [CW-1:0] fifo_count;

  assign m_arsize  = 3'd2;
  assign m_arburst = 2'b01;
  assign m_awsize  = 3'd2;
  assign m_awburst = 2'b01;
  assign m_wstrb   = 4'hF;
  assign m_rready  = 1'b1;
  assign m_bready  = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; start_q <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      start_q <= 1'b0;
      if (cfg_we && !busy_q) begin
        case (cfg_addr)
          4'h0: src_q <= cfg_wdata;
          4'h4: dst_q <= cfg_wdata;
          4'h8: cnt_q <= cfg_wdata;
          4'hC: if (cfg_wdata[0]) begin
            done_q  <= (cnt_q == '0);
            busy_q  <= (cnt_q != '0);
            start_q <= (cnt_q != '0);
            err_q   <= 1'b0;
          end
          default: ;
        endcase
      end
      if (busy_q && (rd_err || wr_err)) err_q <= 1'b1;
      if (busy_q && !start_q && wr_idle) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (cfg_re) begin
        case (cfg_addr)
          4'h0:    cfg_rdata <= src_q;
          4'h4:    cfg_rdata <= dst_q;
          4'h8:    cfg_rdata <= cnt_q;
          4'hC:    cfg_rdata <= {29'd0, err_q, done_q, busy_q};
          default: cfg_rdata <= '0;
        endcase
      end
    end
  end

  copy_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(m_rdata), .pop(pop),
    .dout(fifo_dout), .count(fifo_count));

  copy_rd_ctrl #(.MAX_BURST(MAX_BURST), .MAX_OUT(MAX_RD_OUT), .DEPTH(DEPTH), .CW(CW)) u_rd (
    .clk(clk), .rst(rst), .start(start_q), .base(src_q), .total(cnt_q),
    .fifo_count(fifo_count), .araddr(m_araddr), .arlen(m_arlen),
    .arvalid(m_arvalid), .arready(m_arready), .rvalid(m_rvalid),
    .rlast(m_rlast), .rresp(m_rresp), .push(push), .err(rd_err));

  copy_wr_ctrl #(.MAX_BURST(MAX_BURST), .MAX_OUT(MAX_WR_OUT), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .start(start_q), .base(dst_q), .total(cnt_q),
    .fifo_count(fifo_count), .fifo_dout(fifo_dout), .pop(pop),
    .awaddr(m_awaddr), .awlen(m_awlen), .awvalid(m_awvalid), .awready(m_awready),
    .wdata(m_wdata), .wlast(m_wlast), .wvalid(m_wvalid), .wready(m_wready),
    .bvalid(m_bvalid), .bresp(m_bresp), .err(wr_err), .idle(wr_idle));

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !m_arvalid && !m_awvalid && !m_wvalid);
  p_zero_done_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !busy_q && cfg_addr == 4'hC && cfg_wdata[0] && cnt_q == '0)
      |=> done_q && !busy_q);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_q && !(cfg_we && cfg_addr == 4'hC) |=> err_q);
endmodule

// File: tb/test_burst_copy_engine.sv
module test_burst_copy_engine;
  localparam int MAXB = 8;
  localparam int MRD  = 2;
  localparam int MWR  = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_re = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [31:0] m_araddr, m_awaddr, m_rdata = '0, m_wdata;
  logic [7:0] m_arlen, m_awlen;
  logic [2:0] m_arsize, m_awsize;
  logic [1:0] m_arburst, m_awburst, m_rresp = '0, m_bresp = '0;
  logic m_arvalid, m_arready = 0, m_rlast = 0, m_rvalid = 0, m_rready;
  logic m_awvalid, m_awready = 0, m_wlast, m_wvalid, m_wready = 0;
  logic [3:0] m_wstrb;
  logic m_bvalid = 0, m_bready;

  burst_copy_engine #(.MAX_BURST(MAXB), .MAX_RD_OUT(MRD), .MAX_WR_OUT(MWR)) i_burst_copy_engine (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
    .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory and reference state
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rq_a[$], aq_a[$];
  int rq_l[$], aq_l[$];
  int r_beat = 0, w_beat = 0, b_pend = 0, rd_out = 0, wr_out = 0;
  int rd_beats = 0, wr_beats = 0, ar_bursts = 0;
  logic [31:0] exp_ar = 0, exp_aw = 0, cur_src = 0, cur_dst = 0, err_addr = 32'hFFFF_FFFF;
  bit ar_hs = 0, r_hs = 0, r_lq = 0, aw_hs = 0, w_hs = 0, w_lq = 0, b_hs = 0, w_stall = 0;
  logic [31:0] ar_a, aw_a, w_d;
  int ar_l, aw_l;
  logic [2:0] ar_sz, aw_sz;
  logic [1:0] ar_bu, aw_bu;
  logic [3:0] w_st;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : (32'hDEAD_0000 ^ a);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (ar_hs) begin
        chk(ar_a == exp_ar, "R2", "read burst address", ar_a, exp_ar);
        chk(ar_sz == 3'd2 && ar_bu == 2'b01, "R2", "read size/type", {ar_sz, ar_bu}, {3'd2, 2'b01});
        chk(ar_l + 1 <= MAXB, "R3", "read burst beats", ar_l + 1, MAXB);
        chk(int'(ar_a[11:0]) + 4 * (ar_l + 1) <= 4096, "R4", "read page cross", ar_a, ar_l);
        rq_a.push_back(ar_a); rq_l.push_back(ar_l);
        exp_ar = ar_a + 32'(4 * (ar_l + 1));
        rd_beats += ar_l + 1; ar_bursts++; rd_out++;
        chk(rd_out <= MRD, "R5", "reads outstanding", rd_out, MRD);
      end
      if (r_hs) begin
        if (r_lq) begin void'(rq_a.pop_front()); void'(rq_l.pop_front()); r_beat = 0; rd_out--; end
        else r_beat++;
      end
      if (aw_hs) begin
        chk(aw_a == exp_aw, "R2", "write burst address", aw_a, exp_aw);
        chk(aw_sz == 3'd2 && aw_bu == 2'b01, "R2", "write size/type", {aw_sz, aw_bu}, {3'd2, 2'b01});
        chk(aw_l + 1 <= MAXB, "R3", "write burst beats", aw_l + 1, MAXB);
        chk(int'(aw_a[11:0]) + 4 * (aw_l + 1) <= 4096, "R4", "write page cross", aw_a, aw_l);
        aq_a.push_back(aw_a); aq_l.push_back(aw_l);
        exp_aw = aw_a + 32'(4 * (aw_l + 1));
        wr_out++;
        chk(wr_out <= MWR, "R5", "writes outstanding", wr_out, MWR);
      end
      if (w_stall) chk(m_wvalid, "R7", "wvalid dropped mid-burst", m_wvalid, 1);
      if (w_hs) begin
        if (aq_a.size() == 0) chk(0, "R7", "write data before address", 0, 1);
        else begin
          logic [31:0] wa, ex;
          wa = aq_a[0] + 32'(4 * w_beat);
          ex = rd_mem(cur_src + (wa - cur_dst));
          chk(w_d == ex, "R1", "copied word", w_d, ex);
          chk(w_lq == (w_beat == aq_l[0]), "R2", "wlast position", w_lq, w_beat == aq_l[0]);
          chk(w_st == 4'hF, "R2", "byte enables", w_st, 4'hF);
          mem[wa] = w_d; wr_beats++;
          if (w_beat == aq_l[0]) begin
            void'(aq_a.pop_front()); void'(aq_l.pop_front()); w_beat = 0; b_pend++;
          end else w_beat++;
        end
      end
      if (b_hs) begin b_pend--; wr_out--; end
    end
    // drive memory side for the next edge
    m_arready = ($urandom_range(0, 2) != 0);
    m_awready = ($urandom_range(0, 2) != 0);
    m_wready  = ($urandom_range(0, 3) != 0);
    if (!rst && rq_a.size() > 0 && $urandom_range(0, 3) != 0) begin
      logic [31:0] ra;
      ra = rq_a[0] + 32'(4 * r_beat);
      m_rvalid = 1; m_rdata = rd_mem(ra); m_rlast = (r_beat == rq_l[0]);
      m_rresp = (ra == err_addr) ? 2'b10 : 2'b00;
    end else begin
      m_rvalid = 0; m_rlast = 0; m_rresp = 2'b00;
    end
    m_bvalid = !rst && b_pend > 0 && ($urandom_range(0, 2) != 0);
    m_bresp  = 2'b00;
    // latch what the next edge will transfer
    ar_hs = m_arvalid && m_arready; ar_a = m_araddr; ar_l = int'(m_arlen);
    ar_sz = m_arsize; ar_bu = m_arburst;
    aw_hs = m_awvalid && m_awready; aw_a = m_awaddr; aw_l = int'(m_awlen);
    aw_sz = m_awsize; aw_bu = m_awburst;
    r_hs = m_rvalid && m_rready; r_lq = m_rlast;
    w_hs = m_wvalid && m_wready; w_d = m_wdata; w_lq = m_wlast; w_st = m_wstrb;
    w_stall = m_wvalid && !m_wready;
    b_hs = m_bvalid && m_bready;
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_re = 1; cfg_addr = a;
    @(negedge clk); cfg_re = 0; d = cfg_rdata;
  endtask

  task automatic run_copy(input logic [31:0] src, input logic [31:0] dst,
                          input int n, input bit exp_err);
    logic [31:0] st;
    int polls = 0, b0;
    for (int i = 0; i < n; i++) mem[src + 32'(4 * i)] = {8'hA5, src[7:0], 16'(i)} ^ dst;
    cur_src = src; cur_dst = dst; exp_ar = src; exp_aw = dst;
    rd_beats = 0; wr_beats = 0; b0 = ar_bursts;
    reg_write(4'h0, src); reg_write(4'h4, dst); reg_write(4'h8, 32'(n));
    reg_write(4'hC, 32'd1);
    st = 0;
    while (!st[1] && polls < 5000) begin reg_read(4'hC, st); polls++; end
    chk(st[1] == 1'b1, "R8", "done reached", st, 2);
    chk(st[0] == 1'b0, "R11", "busy clear at done", st[0], 0);
    chk(wr_out == 0 && b_pend == 0, "R8", "responses pending at done", wr_out, 0);
    chk(st[2] == exp_err, "R9", "error flag", st[2], exp_err);
    chk(rd_beats == n, "R3", "read beats total", rd_beats, n);
    chk(wr_beats == n, "R3", "write beats total", wr_beats, n);
    if (n == 0) begin
      chk(polls == 1, "R10", "zero count done at once", polls, 1);
      chk(ar_bursts == b0, "R10", "no bus transfer", ar_bursts - b0, 0);
    end
    for (int i = 0; i < n; i++) begin
      logic [31:0] got, ex;
      got = rd_mem(dst + 32'(4 * i)); ex = rd_mem(src + 32'(4 * i));
      if (got != ex) chk(0, "R1", "destination word", got, ex);
    end
    chk(1, "R1", "destination scan", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!m_arvalid && !m_awvalid && !m_wvalid, "R8", "no valids after reset",
        {m_arvalid, m_awvalid, m_wvalid}, 0);
    reg_read(4'hC, v); chk(v == 0, "R11", "status reset value", v, 0);
    reg_read(4'h8, v); chk(v == 0, "R11", "count reset value", v, 0);
    reg_write(4'h0, 32'h1234_5670); reg_read(4'h0, v);
    chk(v == 32'h1234_5670, "R11", "source readback", v, 32'h1234_5670);
    // R10: empty copy
    run_copy(32'h0000_0100, 32'h0000_0800, 0, 0);
    // R1 R3: aligned, count not a multiple of the burst
    run_copy(32'h0001_0000, 32'h0002_0000, 37, 0);
    // R4: both pointers just below a page edge
    run_copy(32'h0000_1FF0, 32'h0003_3FE8, 30, 0);
    // R9: error response mid-copy, then a clean run clears it
    err_addr = 32'h0004_000C;
    run_copy(32'h0004_0000, 32'h0005_0000, 12, 1);
    err_addr = 32'hFFFF_FFFF;
    run_copy(32'h0006_0FE0, 32'h0007_0000, 50, 0);
    // R11: count register holds last value, writes while idle only
    reg_read(4'h8, v); chk(v == 50, "R11", "count readback", v, 50);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule